// File: doc/BRIEF.md
# Swing and emphasis level encoder

This block sits between a link-training controller and the lane-drive configuration registers of a serial display transmitter. A request carries the lane count, a link-rate code, a flag that asks for a rate change, a flag that asks for new drive levels, and one 2-bit voltage-swing level and one 2-bit pre-emphasis level per lane. The block first decides whether the request is legal. An illegal request produces a one-cycle error pulse and nothing else. A legal request that asks for new drive levels turns into a stream of masked register writes. Each active lane gets three writes: its emphasis code, its amplitude code and its amplitude-scale code.

The controller is a small state machine with five named states. **IDLE** waits for a request and captures it. **CHECK** judges the captured request. From CHECK the *reject* transition goes to **FAIL**, the *emit* transition goes to **EMIT** (legal, levels requested), and the *skip* transition goes to **FIN** (legal, no levels requested). **EMIT** issues one write per cycle. It steps through emphasis, amplitude and scale for lane 0, then for lane 1, and so on. The *last-write* transition goes to **FIN**. FAIL and FIN each last one cycle and then take the *return* transition back to IDLE.

The register bank that receives the writes is outside this block, and so is the clock-generator power sequencing. A write is a triple: a register select, a 16-bit field mask and 16-bit data. The receiving bank updates only the masked bits.

Top module: `swing_emph_encoder`

## Requirements
- R1: A request is legal only if `req_lanes` (a binary count) is 1, 2 or 4. Counts 0, 3, 5, 6 and 7 are rejected.
- R2: When `req_set_rate` is 1, `req_rate` must be 1 (the 1.62 Gb/s code) or 2 (the 2.7 Gb/s code), and codes 0 and 3 are rejected. When `req_set_rate` is 0, `req_rate` has no effect.
- R3: When `req_set_volt` is 1, every active lane L (L < `req_lanes`) must have swing + pre-emphasis ≤ 3. Lane L's levels sit at bits [2L+1:2L] of `req_swing` and `req_pre`. The levels of inactive lanes are not checked, and when `req_set_volt` is 0 no levels are checked.
- R4: A rejected request raises `err` for exactly one cycle, in the second cycle after the accepting edge. It issues no write and no `done`, and the block is idle in the next cycle.
- R5: A legal request with `req_set_volt` = 1 issues 3 × `req_lanes` writes, one per cycle, starting in the cycle after CHECK. Lanes go in ascending order. Within a lane the order is emphasis (`wr_sel` = 0), then amplitude (`wr_sel` = 1), then scale (`wr_sel` = 2).
- R6: The write fields for lane L are: emphasis is 4 bits at [4L+3:4L], amplitude is 3 bits at [4L+2:4L], and scale is 2 bits at [2L+1:2L]. `wr_mask` covers exactly that field, and `wr_data` is zero outside it.
- R7: The amplitude/emphasis codes for (swing, pre) are as follows. Swing 0 with pre 0..3 gives amplitude 1, 2, 3, 4 and emphasis 0x0, 0x4, 0x8, 0xD. Swing 1 with pre 0..2 gives amplitude 3, 5, 6 and emphasis 0x0, 0x7, 0x6. Swing 2 with pre 0..1 gives amplitude 5, 7 and emphasis 0x0, 0x4. Swing 3 with pre 0 gives amplitude 7 and emphasis 0x0.
- R8: The amplitude-scale code written for every legal lane is 1.
- R9: A legal request with `req_set_volt` = 0 issues no write. It raises `done` in the cycle after CHECK.
- R10: `busy` is high from the cycle after the accepting edge through the `done` or `err` cycle. `done` lasts one cycle and follows the last write directly.
- R11: `req_valid` while `busy` is high is ignored. The request being processed produces exactly its own outputs.
- R12: After reset the block is idle, and `busy`, `err`, `done`, `wr_valid`, `wr_mask` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_lanes | input | 3 | Number of active lanes |
| req_rate | input | 2 | Link-rate code (1: 1.62 Gb/s, 2: 2.7 Gb/s) |
| req_set_rate | input | 1 | Rate change requested |
| req_set_volt | input | 1 | Drive-level change requested |
| req_swing | input | 8 | Swing level per lane, 2 bits each |
| req_pre | input | 8 | Pre-emphasis level per lane, 2 bits each |
| busy | output | 1 | Request in progress |
| err | output | 1 | One-cycle reject pulse |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Write strobe |
| wr_sel | output | 2 | Target register: 0 emphasis, 1 amplitude, 2 scale |
| wr_mask | output | 16 | Bits the write may change |
| wr_data | output | 16 | Write data, inside the mask |

## Verification
The bench builds the block with its default parameters: four lanes, 2-bit levels and 16-bit registers. With these values every lane count from 0 to 7 can be applied, so the odd count 3 and the over-range counts 5 to 7 are both reachable. Every swing/pre-emphasis pair of the triangular table can be driven, and so can the over-budget pairs. The four lanes also place fields at the highest bit positions of the registers, which exposes any field-offset error. The reference model expects the same timing for every request, so the bench compares the exact cycle of each write, of `done` and of `err`.

// File: rtl/swing_enc_pkg.sv
package swing_enc_pkg;

    typedef enum logic [1:0] {
        SEL_EMPH  = 2'd0,
        SEL_AMP   = 2'd1,
        SEL_SCALE = 2'd2
    } wr_sel_e;

    localparam logic [1:0] RATE_LOW  = 2'd1;
    localparam logic [1:0] RATE_HIGH = 2'd2;

    typedef struct packed {
        logic [2:0] amp;
        logic [3:0] emph;
        logic [1:0] scale;
    } lvl_code_t;

    function automatic lvl_code_t level_code(input logic [1:0] sw, input logic [1:0] pe);
        lvl_code_t c;
        c.scale = 2'd1;
        unique case ({sw, pe})
            4'b00_00: begin c.amp = 3'd1; c.emph = 4'h0; end
            4'b00_01: begin c.amp = 3'd2; c.emph = 4'h4; end
            4'b00_10: begin c.amp = 3'd3; c.emph = 4'h8; end
            4'b00_11: begin c.amp = 3'd4; c.emph = 4'hD; end
            4'b01_00: begin c.amp = 3'd3; c.emph = 4'h0; end
            4'b01_01: begin c.amp = 3'd5; c.emph = 4'h7; end
            4'b01_10: begin c.amp = 3'd6; c.emph = 4'h6; end
            4'b10_00: begin c.amp = 3'd5; c.emph = 4'h0; end
            4'b10_01: begin c.amp = 3'd7; c.emph = 4'h4; end
            4'b11_00: begin c.amp = 3'd7; c.emph = 4'h0; end
            default:  begin c.amp = 3'd0; c.emph = 4'h0; c.scale = 2'd0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/swing_req_check.sv
module swing_req_check #(
    parameter int NUM_LANES = 4,
    parameter int LVL_W     = 2,
    parameter int CNT_W     = 3
) (
    input  logic [CNT_W-1:0]           lanes,
    input  logic [1:0]                 rate,
    input  logic                       set_rate,
    input  logic                       set_volt,
    input  logic [NUM_LANES*LVL_W-1:0] swing,
    input  logic [NUM_LANES*LVL_W-1:0] pre,
    output logic                       ok
);
    import swing_enc_pkg::*;

    localparam int SUM_W = LVL_W + 1;
    localparam logic [SUM_W-1:0] BUDGET = SUM_W'(3);

    logic [NUM_LANES-1:0] lane_bad;
    logic                 lanes_ok;
    logic                 rate_ok;
    logic                 volt_ok;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [SUM_W-1:0] sum;
        assign sum         = {1'b0, swing[g*LVL_W +: LVL_W]} + {1'b0, pre[g*LVL_W +: LVL_W]};
        assign lane_bad[g] = (CNT_W'(g) < lanes) && (sum > BUDGET);
    end

    always_comb begin
        lanes_ok = (lanes != '0) && (lanes <= CNT_W'(NUM_LANES))
                   && ((lanes & (lanes - CNT_W'(1))) == '0);
        rate_ok  = !set_rate || (rate == RATE_LOW) || (rate == RATE_HIGH);
        volt_ok  = !set_volt || (lane_bad == '0);
        ok       = lanes_ok && rate_ok && volt_ok;
    end

endmodule

// File: rtl/swing_code_map.sv
module swing_code_map #(
    parameter int NUM_LANES = 4,
    parameter int LVL_W     = 2,
    parameter int IDX_W     = 2
) (
    input  logic [IDX_W-1:0]           lane_idx,
    input  logic [NUM_LANES*LVL_W-1:0] swing,
    input  logic [NUM_LANES*LVL_W-1:0] pre,
    output swing_enc_pkg::lvl_code_t   code
);
    import swing_enc_pkg::*;

    logic [LVL_W-1:0] sw_sel;
    logic [LVL_W-1:0] pe_sel;

    always_comb begin
        sw_sel = swing[lane_idx*LVL_W +: LVL_W];
        pe_sel = pre[lane_idx*LVL_W +: LVL_W];
        code   = level_code(sw_sel, pe_sel);
    end

endmodule

// File: rtl/swing_wr_pack.sv
module swing_wr_pack #(
    parameter int REG_W = 16,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0]                lane_idx,
    input  swing_enc_pkg::wr_sel_e          sel,
    input  swing_enc_pkg::lvl_code_t        code,
    output logic [REG_W-1:0]                mask,
    output logic [REG_W-1:0]                data
);
    import swing_enc_pkg::*;

    localparam int EMPH_STRIDE  = 4;
    localparam int AMP_STRIDE   = 4;
    localparam int SCALE_STRIDE = 2;

    int unsigned sh;

    always_comb begin
        sh   = 0;
        mask = '0;
        data = '0;
        unique case (sel)
            SEL_EMPH: begin
                sh   = int'(lane_idx) * EMPH_STRIDE;
                mask = REG_W'(4'hF) << sh;
                data = REG_W'(code.emph) << sh;
            end
            SEL_AMP: begin
                sh   = int'(lane_idx) * AMP_STRIDE;
                mask = REG_W'(3'h7) << sh;
                data = REG_W'(code.amp) << sh;
            end
            SEL_SCALE: begin
                sh   = int'(lane_idx) * SCALE_STRIDE;
                mask = REG_W'(2'h3) << sh;
                data = REG_W'(code.scale) << sh;
            end
            default: begin
                sh   = 0;
                mask = '0;
                data = '0;
            end
        endcase
    end

endmodule

// File: rtl/swing_emph_encoder.sv
module swing_emph_encoder #(
    parameter int NUM_LANES = 4,
    parameter int LVL_W     = 2,
    parameter int REG_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [$clog2(NUM_LANES):0]      req_lanes,
    input  logic [1:0]                      req_rate,
    input  logic                            req_set_rate,
    input  logic                            req_set_volt,
    input  logic [NUM_LANES*LVL_W-1:0]      req_swing,
    input  logic [NUM_LANES*LVL_W-1:0]      req_pre,
    output logic                            busy,
    output logic                            err,
    output logic                            done,
    output logic                            wr_valid,
    output logic [1:0]                      wr_sel,
    output logic [REG_W-1:0]                wr_mask,
    output logic [REG_W-1:0]                wr_data
);
    import swing_enc_pkg::*;

    localparam int IDX_W = $clog2(NUM_LANES);
    localparam int CNT_W = IDX_W + 1;
    localparam int LVL_BITS = NUM_LANES * LVL_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_EMIT  = 3'd2,
        ST_FAIL  = 3'd3,
        ST_FIN   = 3'd4
    } state_e;

    state_e               state_q, state_d;
    logic [IDX_W-1:0]     lane_q, lane_d;
    wr_sel_e              step_q, step_d;
    logic [CNT_W-1:0]     lanes_q;
    logic [1:0]           rate_q;
    logic                 set_rate_q;
    logic                 set_volt_q;
    logic [LVL_BITS-1:0]  swing_q;
    logic [LVL_BITS-1:0]  pre_q;

    logic                 req_ok;
    lvl_code_t            lane_code;
    logic [REG_W-1:0]     pack_mask;
    logic [REG_W-1:0]     pack_data;
    logic                 last_lane;

    swing_req_check #(
        .NUM_LANES(NUM_LANES),
        .LVL_W    (LVL_W),
        .CNT_W    (CNT_W)
    ) u_check (
        .lanes   (lanes_q),
        .rate    (rate_q),
        .set_rate(set_rate_q),
        .set_volt(set_volt_q),
        .swing   (swing_q),
        .pre     (pre_q),
        .ok      (req_ok)
    );

    swing_code_map #(
        .NUM_LANES(NUM_LANES),
        .LVL_W    (LVL_W),
        .IDX_W    (IDX_W)
    ) u_map (
        .lane_idx(lane_q),
        .swing   (swing_q),
        .pre     (pre_q),
        .code    (lane_code)
    );

    swing_wr_pack #(
        .REG_W(REG_W),
        .IDX_W(IDX_W)
    ) u_pack (
        .lane_idx(lane_q),
        .sel     (step_q),
        .code    (lane_code),
        .mask    (pack_mask),
        .data    (pack_data)
    );

    assign last_lane = ({1'b0, lane_q} == (lanes_q - CNT_W'(1)));

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lane_q     <= '0;
            step_q     <= SEL_EMPH;
            lanes_q    <= '0;
            rate_q     <= '0;
            set_rate_q <= 1'b0;
            set_volt_q <= 1'b0;
            swing_q    <= '0;
            pre_q      <= '0;
        end else begin
            state_q <= state_d;
            lane_q  <= lane_d;
            step_q  <= step_d;
            if (state_q == ST_IDLE && req_valid) begin
                lanes_q    <= req_lanes;
                rate_q     <= req_rate;
                set_rate_q <= req_set_rate;
                set_volt_q <= req_set_volt;
                swing_q    <= req_swing;
                pre_q      <= req_pre;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        lane_d  = lane_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                lane_d = '0;
                step_d = SEL_EMPH;
                if (!req_ok)         state_d = ST_FAIL;
                else if (set_volt_q) state_d = ST_EMIT;
                else                 state_d = ST_FIN;
            end
            ST_EMIT: begin
                if (step_q == SEL_SCALE) begin
                    step_d = SEL_EMPH;
                    if (last_lane) state_d = ST_FIN;
                    else           lane_d  = lane_q + IDX_W'(1);
                end else begin
                    step_d = wr_sel_e'(step_q + 2'd1);
                end
            end
            ST_FAIL: state_d = ST_IDLE;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        err      = (state_q == ST_FAIL);
        done     = (state_q == ST_FIN);
        wr_valid = (state_q == ST_EMIT);
        wr_sel   = wr_valid ? step_q : 2'd0;
        wr_mask  = wr_valid ? pack_mask : '0;
        wr_data  = wr_valid ? pack_data : '0;
    end

    // Reject pulse lasts one cycle and returns to idle
    p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !busy));

    // A reject never follows a write
    p_err_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(wr_valid));

    // Data stays inside a non-empty mask
    p_data_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data & ~wr_mask) == '0 && wr_mask != '0));

    // Scale write carries code 1 in its lane field
    p_scale_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == SEL_SCALE) |-> (((wr_data >> (int'(lane_q) * 2)) & REG_W'(3)) == REG_W'(1)));

    // Completion pulse lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // A request offered while busy leaves the captured request untouched
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(lanes_q) && $stable(swing_q) && $stable(pre_q)));

endmodule

// File: tb/swing_emph_encoder_tb.sv
module swing_emph_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_lanes = '0;
    logic [1:0]  req_rate = '0;
    logic        req_set_rate = 1'b0;
    logic        req_set_volt = 1'b0;
    logic [7:0]  req_swing = '0;
    logic [7:0]  req_pre = '0;
    logic        busy, err, done, wr_valid;
    logic [1:0]  wr_sel;
    logic [15:0] wr_mask, wr_data;

    always #10 clk = ~clk;

    swing_emph_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lanes(req_lanes),
        .req_rate(req_rate), .req_set_rate(req_set_rate), .req_set_volt(req_set_volt),
        .req_swing(req_swing), .req_pre(req_pre), .busy(busy), .err(err), .done(done),
        .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_data(wr_data)
    );

    typedef struct packed {
        logic        busy;
        logic        err;
        logic        done;
        logic        wv;
        logic [1:0]  sel;
        logic [15:0] mask;
        logic [15:0] data;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;

    int amp_tab  [16] = '{1, 2, 3, 4, 3, 5, 6, 0, 5, 7, 0, 0, 7, 0, 0, 0};
    int emph_tab [16] = '{0, 4, 8, 13, 0, 7, 6, 0, 0, 4, 0, 0, 0, 0, 0, 0};

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic compare();
        obs_t  e, a;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = '0;
            t = "R10 idle";
        end
        a = '{busy, err, done, wr_valid, wr_sel, wr_mask, wr_data};
        n_checks++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: got b%0b e%0b d%0b v%0b s%0d m%h x%h, expected b%0b e%0b d%0b v%0b s%0d m%h x%h",
                t, a.busy, a.err, a.done, a.wv, a.sel, a.mask, a.data,
                e.busy, e.err, e.done, e.wv, e.sel, e.mask, e.data);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic push(obs_t o, string t);
        exp_q.push_back(o);
        tag_q.push_back(t);
    endtask

    task automatic model(int lanes, int rate, bit sr, bit sv, logic [7:0] sw, logic [7:0] pe);
        bit    lanes_ok, rate_ok, volt_ok;
        string why;
        lanes_ok = (lanes == 1 || lanes == 2 || lanes == 4);
        rate_ok  = !sr || rate == 1 || rate == 2;
        volt_ok  = 1'b1;
        if (sv) for (int l = 0; l < lanes && l < 4; l++)
            if (int'(sw[2*l +: 2]) + int'(pe[2*l +: 2]) > 3) volt_ok = 1'b0;
        push('{1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0}, "R10 check cycle");
        if (!(lanes_ok && rate_ok && volt_ok)) begin
            why = !lanes_ok ? "R1 lane count" : (!rate_ok ? "R2 rate" : "R3 budget");
            push('{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0}, {"R4 reject ", why});
            return;
        end
        if (sv) begin
            for (int l = 0; l < lanes; l++) begin
                int idx = int'(sw[2*l +: 2]) * 4 + int'(pe[2*l +: 2]);
                push('{1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 16'hF << (4*l), 16'(emph_tab[idx]) << (4*l)},
                     "R5/R6/R7 emphasis");
                push('{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 16'h7 << (4*l), 16'(amp_tab[idx]) << (4*l)},
                     "R5/R6/R7 amplitude");
                push('{1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 16'h3 << (2*l), 16'h1 << (2*l)},
                     "R5/R6/R8 scale");
            end
            push('{1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0, 16'h0}, "R10 done");
        end else begin
            push('{1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0, 16'h0}, "R9 done without writes");
        end
    endtask

    task automatic issue(int lanes, int rate, bit sr, bit sv, logic [7:0] sw, logic [7:0] pe,
                         int busy_pokes);
        req_lanes    = 3'(lanes);
        req_rate     = 2'(rate);
        req_set_rate = sr;
        req_set_volt = sv;
        req_swing    = sw;
        req_pre      = pe;
        req_valid    = 1'b1;
        model(lanes, rate, sr, sv, sw, pe);
        step();
        // R11: offered while busy, must be ignored
        for (int i = 0; i < busy_pokes; i++) begin
            req_lanes = 3'd3;
            req_swing = 8'hFF;
            req_pre   = 8'hFF;
            req_valid = 1'b1;
            step();
        end
        req_valid = 1'b0;
        while (exp_q.size() > 0) step();
        step();
    endtask

    initial begin
        // R12: outputs idle during and after reset
        repeat (2) step();
        rst_n = 1'b1;
        step();

        // R5 R6 R7 R8: all ten level pairs over three requests
        issue(4, 0, 0, 1, {2'd3, 2'd2, 2'd1, 2'd0}, {2'd0, 2'd1, 2'd2, 2'd3}, 0);
        issue(4, 1, 1, 1, {2'd1, 2'd0, 2'd0, 2'd0}, {2'd0, 2'd2, 2'd1, 2'd0}, 0);
        issue(4, 2, 1, 1, {2'd0, 2'd2, 2'd1, 2'd1}, {2'd3, 2'd0, 2'd1, 2'd0}, 0);
        // R1 legal smaller counts; R3 inactive lanes over budget
        issue(1, 0, 0, 1, {2'd3, 2'd3, 2'd3, 2'd2}, {2'd3, 2'd3, 2'd3, 2'd1}, 0);
        issue(2, 0, 0, 1, {2'd3, 2'd3, 2'd1, 2'd0}, {2'd3, 2'd3, 2'd1, 2'd2}, 0);
        // R1 illegal counts
        issue(0, 1, 1, 1, 8'h00, 8'h00, 0);
        issue(3, 1, 1, 1, 8'h00, 8'h00, 0);
        issue(5, 1, 1, 0, 8'h00, 8'h00, 0);
        issue(7, 1, 1, 0, 8'h00, 8'h00, 0);
        // R2 rate codes
        issue(4, 0, 1, 0, 8'h00, 8'h00, 0);
        issue(4, 3, 1, 0, 8'h00, 8'h00, 0);
        issue(2, 1, 1, 0, 8'h00, 8'h00, 0);
        issue(2, 2, 1, 0, 8'h00, 8'h00, 0);
        issue(2, 3, 0, 0, 8'h00, 8'h00, 0);
        // R3 budget on active lane, and unchecked when levels not requested
        issue(4, 1, 1, 1, {2'd2, 2'd0, 2'd0, 2'd0}, {2'd2, 2'd0, 2'd0, 2'd0}, 0);
        issue(2, 1, 1, 1, {2'd0, 2'd0, 2'd1, 2'd0}, {2'd0, 2'd0, 2'd3, 2'd0}, 0);
        issue(4, 1, 1, 0, 8'hFF, 8'hFF, 0);
        // R11 requests while busy, on a write stream and on a reject
        issue(4, 1, 1, 1, {2'd0, 2'd1, 2'd2, 2'd3}, {2'd3, 2'd2, 2'd1, 2'd0}, 6);
        issue(6, 1, 1, 1, 8'h00, 8'h00, 1);
        // R9 then immediate back-to-back R5
        issue(1, 2, 1, 0, 8'h00, 8'h00, 0);
        issue(1, 2, 1, 1, 8'h03, 8'h00, 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule